// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point words and returns a 32-bit product in the same format. Each word has a sign bit in bit 31, an 8-bit exponent in bits 30:23 stored with an offset of 127, and a 23-bit fraction in bits 22:0. Normal numbers carry an implied leading one. The block splits each operand into its fields and restores the implied one. It forms the 48-bit product of the two 24-bit significands. It then normalizes, rounds with guard, round and sticky bits, and packs the result.

The datapath has two register stages. Stage one holds the significand product, the combined exponent and the operand classes. Stage two normalizes, rounds, resolves special encodings and registers the outputs, so a result appears two clock edges after its operands. A new operation may enter on every cycle. The rounding mode travels with its operands through the pipeline.

Inputs with a zero exponent field (zero or subnormal) are treated as signed zero. An exponent field of all ones with a zero fraction is infinity; with a nonzero fraction it is NaN. Exponent overflow and underflow each raise a flag that is qualified by the output valid.

Top module: `sp_fmul`

## Requirements
- R1: The result sign is the XOR of the two operand signs for every result that is not NaN.
- R2: A finite product has biased exponent E_A + E_B - 127. When the significand product is 2 or more, it is shifted right by one and the exponent is raised by one. Example: 0x3FC00000 x 0x40200000 gives 0x40700000, and 0x3FC00000 x 0x3FC00000 gives 0x40100000.
- R3: Rounding mode 2'b00 rounds to nearest. An exact tie (guard 1, round and sticky 0) rounds to the even fraction.
- R4: Rounding mode 2'b01 truncates the magnitude toward zero.
- R5: Rounding mode 2'b10 rounds toward plus infinity. A positive inexact result is incremented; a negative one is truncated.
- R6: Rounding mode 2'b11 rounds toward minus infinity. A negative inexact result is incremented in magnitude; a positive one is truncated.
- R7: A NaN on either input, or zero times infinity, gives the quiet NaN 0x7FC00000 with both flags low.
- R8: Infinity times a nonzero finite value gives an infinity with the XOR sign. Zero times a finite value gives a signed zero. A subnormal input counts as zero. None of these raise a flag.
- R9: A rounded exponent of 255 or more raises the overflow flag (ovf_flag). The result is infinity in modes 00 and in the mode that rounds toward the result's sign. It is the largest finite value (exponent 254, fraction all ones) in mode 01 and in the mode that rounds away from the result's sign.
- R10: A rounded exponent below 1 gives a zero with the product's sign and raises the underflow flag (udf_flag). An exponent of exactly 1 stays a normal result with no flag.
- R11: If rounding carries out of the 24-bit significand, the fraction becomes zero and the exponent rises by one.
- R12: out_valid is high two edges after in_valid, with no gaps for back-to-back operations. Reset clears out_valid, result and both flags. Both flags are low whenever out_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and mode are present this cycle |
| op_a | input | 32 | First operand word |
| op_b | input | 32 | Second operand word |
| rnd_mode | input | 2 | 00 nearest-even, 01 toward zero, 10 toward plus infinity, 11 toward minus infinity |
| out_valid | output | 1 | result and flags hold a new product |
| result | output | 32 | Product word |
| ovf_flag | output | 1 | Exponent overflow on this result |
| udf_flag | output | 1 | Exponent underflow on this result (flushed to zero) |

## Verification
A wrong guard, round or sticky bit shows up as a result one unit in the last place off. It appears in only one rounding mode and only for operands whose discarded bits fall at that boundary, two edges after the operands. For that reason each mode gets operands placed just below, exactly at and just above the halfway point. A corrupt exponent register or a missed renormalization shifts the result by a factor of two, or turns a normal result into a flagged overflow or underflow, within the same two-cycle latency. A pipeline that loses a stage or carries one operation's class into another shows up as a mismatched product in a back-to-back stream.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_UP   = 2'b10,
    RM_DOWN = 2'b11
  } rmode_e;

  typedef struct packed {
    logic is_zero;
    logic is_inf;
    logic is_nan;
  } opclass_t;

endpackage

// File: rtl/fmul_unpack.sv
module fmul_unpack #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] word,
  output logic                  sign,
  output logic [EXP_W-1:0]      exp_f,
  output logic [FRAC_W:0]       sig,
  output fmul_pkg::opclass_t    cls
);
  localparam int W = 1 + EXP_W + FRAC_W;

  logic [FRAC_W-1:0] frac;
  logic exp_ones, exp_nil, frac_nz;

  assign sign     = word[W-1];
  assign exp_f    = word[W-2:FRAC_W];
  assign frac     = word[FRAC_W-1:0];
  assign exp_ones = &exp_f;
  assign exp_nil  = ~|exp_f;
  assign frac_nz  = |frac;

  // subnormals flush: zero exponent field means the value is zero
  assign sig         = exp_nil ? '0 : {1'b1, frac};
  assign cls.is_zero = exp_nil;
  assign cls.is_inf  = exp_ones & ~frac_nz;
  assign cls.is_nan  = exp_ones & frac_nz;
endmodule

// File: rtl/fmul_sigmul.sv
module fmul_sigmul #(
  parameter int SIG_W = 24
) (
  input  logic [SIG_W-1:0]   a,
  input  logic [SIG_W-1:0]   b,
  output logic [2*SIG_W-1:0] prod
);
  assign prod = {{SIG_W{1'b0}}, a} * {{SIG_W{1'b0}}, b};
endmodule

// File: rtl/fmul_round.sv
module fmul_round #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                          sign,
  input  logic signed [EXP_W+1:0]       exp_sum,
  input  logic [2*(FRAC_W+1)-1:0]       prod,
  input  fmul_pkg::rmode_e              mode,
  output logic [EXP_W+FRAC_W:0]         word,
  output logic                          ovf,
  output logic                          udf
);
  import fmul_pkg::*;

  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int XW     = EXP_W + 2;
  localparam logic signed [XW-1:0] EXP_TOP = XW'((1 << EXP_W) - 1);
  localparam logic signed [XW-1:0] EXP_ONE = XW'(1);

  logic                    top;
  logic [PROD_W-1:0]       norm;
  logic [SIG_W-1:0]        mant;
  logic                    g_bit, r_bit, s_bit, inexact, inc;
  logic [SIG_W:0]          mant_r;
  logic                    carry;
  logic signed [XW-1:0]    exp_n, exp_f;
  logic [FRAC_W-1:0]       frac_f;
  logic                    to_inf;

  // product of two 1.x significands lies in [1,4): top bit marks >= 2
  assign top   = prod[PROD_W-1];
  assign norm  = top ? prod : (prod << 1);
  assign mant  = norm[PROD_W-1 -: SIG_W];
  assign g_bit = norm[PROD_W-1-SIG_W];
  assign r_bit = norm[PROD_W-2-SIG_W];
  assign s_bit = |norm[PROD_W-3-SIG_W:0];
  assign inexact = g_bit | r_bit | s_bit;
  assign exp_n = exp_sum + XW'(top);

  always_comb begin
    unique case (mode)
      RM_NEAR: inc = g_bit & (r_bit | s_bit | mant[0]);
      RM_ZERO: inc = 1'b0;
      RM_UP:   inc = ~sign & inexact;
      RM_DOWN: inc = sign & inexact;
      default: inc = 1'b0;
    endcase
  end

  assign mant_r = {1'b0, mant} + (SIG_W+1)'(inc);
  assign carry  = mant_r[SIG_W];
  // on carry-out the significand is exactly 10.000..., fraction becomes zero
  assign frac_f = carry ? '0 : mant_r[FRAC_W-1:0];
  assign exp_f  = exp_n + XW'(carry);

  assign to_inf = (mode == RM_NEAR) | ((mode == RM_UP) & ~sign) |
                  ((mode == RM_DOWN) & sign);

  always_comb begin
    ovf  = 1'b0;
    udf  = 1'b0;
    word = {sign, exp_f[EXP_W-1:0], frac_f};
    if (exp_f >= EXP_TOP) begin
      ovf  = 1'b1;
      word = to_inf ? {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                    : {sign, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
    end else if (exp_f < EXP_ONE) begin
      udf  = 1'b1;
      word = {sign, {(EXP_W+FRAC_W){1'b0}}};
    end
  end
endmodule

// File: rtl/sp_fmul.sv
module sp_fmul #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [EXP_W+FRAC_W:0]  op_a,
  input  logic [EXP_W+FRAC_W:0]  op_b,
  input  logic [1:0]             rnd_mode,
  output logic                   out_valid,
  output logic [EXP_W+FRAC_W:0]  result,
  output logic                   ovf_flag,
  output logic                   udf_flag
);
  import fmul_pkg::*;

  localparam int W      = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int XW     = EXP_W + 2;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam logic [W-1:0]   QNAN     = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [W-2:0]   INF_MAG  = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [W-2:0]   MAXF_MAG = {{(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};

  // ---------------- operand unpack (one per operand) ----------------
  logic [W-1:0]      op_w  [2];
  logic              sgn_u [2];
  logic [EXP_W-1:0]  exp_u [2];
  logic [SIG_W-1:0]  sig_u [2];
  opclass_t          cls_u [2];

  assign op_w[0] = op_a;
  assign op_w[1] = op_b;

  for (genvar gi = 0; gi < 2; gi++) begin : g_unpack
    fmul_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp (
      .word  (op_w[gi]),
      .sign  (sgn_u[gi]),
      .exp_f (exp_u[gi]),
      .sig   (sig_u[gi]),
      .cls   (cls_u[gi])
    );
  end

  logic [PROD_W-1:0] prod_d;
  fmul_sigmul #(.SIG_W(SIG_W)) u_mul (
    .a    (sig_u[0]),
    .b    (sig_u[1]),
    .prod (prod_d)
  );

  logic signed [XW-1:0] exp_sum_d;
  logic                 nan_d, inf_d, zero_d;

  assign exp_sum_d = XW'(exp_u[0]) + XW'(exp_u[1]) - XW'(BIAS);
  assign nan_d  = cls_u[0].is_nan | cls_u[1].is_nan |
                  (cls_u[0].is_zero & cls_u[1].is_inf) |
                  (cls_u[0].is_inf & cls_u[1].is_zero);
  assign inf_d  = cls_u[0].is_inf | cls_u[1].is_inf;
  assign zero_d = cls_u[0].is_zero | cls_u[1].is_zero;

  // ---------------- stage 1 registers ----------------
  logic                 s1_valid, s1_sign, s1_nan, s1_inf, s1_zero;
  logic signed [XW-1:0] s1_exp;
  logic [PROD_W-1:0]    s1_prod;
  rmode_e               s1_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_sign  <= 1'b0;
      s1_nan   <= 1'b0;
      s1_inf   <= 1'b0;
      s1_zero  <= 1'b0;
      s1_exp   <= '0;
      s1_prod  <= '0;
      s1_mode  <= RM_NEAR;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_sign <= sgn_u[0] ^ sgn_u[1];
        s1_nan  <= nan_d;
        s1_inf  <= inf_d;
        s1_zero <= zero_d;
        s1_exp  <= exp_sum_d;
        s1_prod <= prod_d;
        s1_mode <= rmode_e'(rnd_mode);
      end
    end
  end

  // ---------------- stage 2: round, special select ----------------
  logic [W-1:0] rnd_word;
  logic         rnd_ovf, rnd_udf;

  fmul_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_rnd (
    .sign    (s1_sign),
    .exp_sum (s1_exp),
    .prod    (s1_prod),
    .mode    (s1_mode),
    .word    (rnd_word),
    .ovf     (rnd_ovf),
    .udf     (rnd_udf)
  );

  logic [W-1:0] res_d;
  logic         ovf_d, udf_d;

  always_comb begin
    ovf_d = 1'b0;
    udf_d = 1'b0;
    if (s1_nan)       res_d = QNAN;
    else if (s1_inf)  res_d = {s1_sign, INF_MAG};
    else if (s1_zero) res_d = {s1_sign, {(W-1){1'b0}}};
    else begin
      res_d = rnd_word;
      ovf_d = rnd_ovf;
      udf_d = rnd_udf;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      ovf_flag  <= 1'b0;
      udf_flag  <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      ovf_flag  <= s1_valid & ovf_d;
      udf_flag  <= s1_valid & udf_d;
      if (s1_valid) result <= res_d;
    end
  end

  // ---------------- assertions ----------------
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= 2'd0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  p_latency_r12: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2) |-> (out_valid == $past(in_valid, 2)));

  p_flags_qual_r12: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!ovf_flag && !udf_flag));

  p_sign_r1: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2 && out_valid && result != QNAN) |->
      (result[W-1] == $past(op_a[W-1] ^ op_b[W-1], 2)));

  p_nan_canon_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (&result[W-2:FRAC_W]) && (|result[FRAC_W-1:0])) |->
      (result == QNAN));

  p_ovf_sat_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ovf_flag) |->
      (result[W-2:0] == INF_MAG || result[W-2:0] == MAXF_MAG));

  p_udf_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && udf_flag) |-> (result[W-2:0] == '0 && !ovf_flag));

  p_stage_r12: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(s1_valid));
endmodule

// File: tb/tb_sp_fmul.sv
module tb_sp_fmul;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] op_a, op_b;
  logic [1:0]  rnd_mode;
  logic        out_valid;
  logic [31:0] result;
  logic        ovf_flag, udf_flag;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  sp_fmul dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .rnd_mode(rnd_mode), .out_valid(out_valid), .result(result),
    .ovf_flag(ovf_flag), .udf_flag(udf_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [33:0] got, input logic [33:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h ovf=%b udf=%b, expected %h ovf=%b udf=%b",
               tag, got[33:2], got[1], got[0], exp[33:2], exp[1], exp[0]);
    end
  endtask

  // one operation, sampled two edges later on a falling edge
  task automatic run_op(input string tag, input logic [31:0] a, input logic [31:0] b,
                        input logic [1:0] m, input logic [31:0] er,
                        input logic eo, input logic eu);
    @(negedge clk);
    op_a = a; op_b = b; rnd_mode = m; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check({tag, " valid"}, {32'h0, out_valid, 1'b0}, {32'h0, 1'b1, 1'b0});
    check(tag, {result, ovf_flag, udf_flag}, {er, eo, eu});
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R12 reset", {result, ovf_flag, udf_flag}, 34'h0);
    check("R12 reset valid", {32'h0, out_valid, 1'b0}, 34'h0);
  endtask

  task automatic t_basic;
    run_op("R2 1.5x2.5",   32'h3FC00000, 32'h40200000, 2'b00, 32'h40700000, 0, 0);
    run_op("R2 1.5x1.5",   32'h3FC00000, 32'h3FC00000, 2'b00, 32'h40100000, 0, 0);
    run_op("R2 2x3",       32'h40000000, 32'h40400000, 2'b00, 32'h40C00000, 0, 0);
    run_op("R1 neg x pos", 32'hBFC00000, 32'h40200000, 2'b00, 32'hC0700000, 0, 0);
    run_op("R1 neg x neg", 32'hBFC00000, 32'hC0200000, 2'b00, 32'h40700000, 0, 0);
  endtask

  task automatic t_round;
    // tie with odd lsb: 0x400001 + half ulp
    run_op("R3 tie odd",   32'h3F800001, 32'h3FC00000, 2'b00, 32'h3FC00002, 0, 0);
    run_op("R3 tie even",  32'h3F800003, 32'h3FC00000, 2'b00, 32'h3FC00004, 0, 0);
    run_op("R3 below half",32'h3F800001, 32'h3FA00000, 2'b00, 32'h3FA00001, 0, 0);
    run_op("R3 above half",32'h3F800001, 32'h3FE00000, 2'b00, 32'h3FE00002, 0, 0);
    run_op("R4 trunc",     32'h3F800001, 32'h3FE00000, 2'b01, 32'h3FE00001, 0, 0);
    run_op("R4 trunc neg", 32'hBF800001, 32'h3FC00000, 2'b01, 32'hBFC00001, 0, 0);
    run_op("R5 up pos",    32'h3F800001, 32'h3FA00000, 2'b10, 32'h3FA00002, 0, 0);
    run_op("R5 up even",   32'h3F800003, 32'h3FC00000, 2'b10, 32'h3FC00005, 0, 0);
    run_op("R5 up neg",    32'hBF800001, 32'h3FC00000, 2'b10, 32'hBFC00001, 0, 0);
    run_op("R6 down neg",  32'hBF800001, 32'h3FC00000, 2'b11, 32'hBFC00002, 0, 0);
    run_op("R6 down pos",  32'h3F800001, 32'h3FE00000, 2'b11, 32'h3FE00001, 0, 0);
    run_op("R5 exact",     32'h3FC00000, 32'h40200000, 2'b10, 32'h40700000, 0, 0);
  endtask

  task automatic t_carry;
    run_op("R11 carry near", 32'h3F800001, 32'h3FFFFFFE, 2'b00, 32'h40000000, 0, 0);
    run_op("R11 no carry rz",32'h3F800001, 32'h3FFFFFFE, 2'b01, 32'h3FFFFFFF, 0, 0);
  endtask

  task automatic t_special;
    run_op("R7 nan in",    32'h7F800001, 32'h3F800000, 2'b00, 32'h7FC00000, 0, 0);
    run_op("R7 neg nan",   32'h3F800000, 32'hFFC00000, 2'b00, 32'h7FC00000, 0, 0);
    run_op("R7 zero x inf",32'h00000000, 32'h7F800000, 2'b00, 32'h7FC00000, 0, 0);
    run_op("R7 sub x inf", 32'hFF800000, 32'h00000005, 2'b00, 32'h7FC00000, 0, 0);
    run_op("R8 inf x -2",  32'h7F800000, 32'hC0000000, 2'b00, 32'hFF800000, 0, 0);
    run_op("R8 zero x -3", 32'h00000000, 32'hC0400000, 2'b00, 32'h80000000, 0, 0);
    run_op("R8 subnormal", 32'h00000001, 32'h3F800000, 2'b00, 32'h00000000, 0, 0);
  endtask

  task automatic t_range;
    run_op("R9 ovf near",  32'h7F000000, 32'h40000000, 2'b00, 32'h7F800000, 1, 0);
    run_op("R9 ovf rz",    32'h7F000000, 32'h40000000, 2'b01, 32'h7F7FFFFF, 1, 0);
    run_op("R9 ovf up neg",32'hFF000000, 32'h40000000, 2'b10, 32'hFF7FFFFF, 1, 0);
    run_op("R9 ovf dn neg",32'hFF000000, 32'h40000000, 2'b11, 32'hFF800000, 1, 0);
    run_op("R9 max ok",    32'h7F000000, 32'h3F800000, 2'b00, 32'h7F000000, 0, 0);
    run_op("R10 udf",      32'h00800000, 32'h3F000000, 2'b00, 32'h00000000, 0, 1);
    run_op("R10 udf neg",  32'h80800000, 32'h3F000000, 2'b10, 32'h80000000, 0, 1);
    run_op("R10 min ok",   32'h00800000, 32'h3F800000, 2'b00, 32'h00800000, 0, 0);
  endtask

  task automatic t_stream;
    logic [31:0] sa [3] = '{32'h3FC00000, 32'h7F800001, 32'h7F000000};
    logic [31:0] sb [3] = '{32'h40200000, 32'h3F800000, 32'h40000000};
    logic [33:0] se [3] = '{{32'h40700000, 2'b00}, {32'h7FC00000, 2'b00},
                            {32'h7F800000, 2'b10}};
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        check("R12 stream valid", {32'h0, out_valid, 1'b0}, {32'h0, 1'b1, 1'b0});
        check("R12 stream", {result, ovf_flag, udf_flag}, se[k-2]);
      end
      if (k < 3) begin
        op_a = sa[k]; op_b = sb[k]; rnd_mode = 2'b00; in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    check("R12 idle", {32'h0, out_valid, ovf_flag}, 34'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; op_a = '0; op_b = '0; rnd_mode = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_round();
    t_carry();
    t_special();
    t_range();
    t_stream();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule